// File: doc/BRIEF.md
# Phase-Ordered Commit Arbiter

This block lets exactly one of N processors publish its finished transaction to shared memory at a time. The order in which grants are issued is the only order the rest of the system sees, so the interconnect that carries commit data needs no ordering of its own.

Every live transaction carries a phase number. Only requesters whose phase equals the current oldest phase may receive a grant.
- Giving each transaction its own increasing phase forces a fully sequential program order.
- Giving several transactions the same phase lets them commit in any order, but no later phase commits until all of them are done. This acts as a barrier.

The arbiter keeps the oldest phase in a register. It moves that register forward only when no live processor still reports it.

Among eligible requesters, the winner is chosen round-robin. It holds the grant until it pulses its done line.

A processor that must perform an irrevocable action, such as reading input, raises its request before finishing its transaction. Once granted, it can no longer be forced to roll back. It keeps the grant through the action and its commit.

Top module: `phase_commit_arbiter`

## Requirements
- R1: After reset, `commit_grant` is all zeros and `oldest_phase` is 0.
- R2: At most one bit of `commit_grant` is set in any cycle.
- R3: A grant is issued only to processor i with `txn_live[i]`, `commit_req[i]` and phase equal to `oldest_phase`. It appears one clock edge after such a request is seen while no grant is held. A request from a live processor with a later phase gets no grant.
- R4: A held grant stays unchanged until the holder's own `commit_done` bit is seen at a clock edge. `commit_done` from any other processor has no effect on the grant.
- R5: On the edge that sees the holder's done, `commit_grant` returns to zero. The next grant can appear no earlier than the following edge.
- R6: Round-robin: after granting processor k, the next grant goes to the first eligible index in the order k+1, k+2, … modulo N. The first grant after reset starts the search at index 0.
- R7: With no grant held and no live processor at the oldest phase, `oldest_phase` moves on the next edge to the nearest phase among live processors, measured forward. With no live processor it holds. It never moves while a grant is held or while a live processor reports the oldest phase.
- R8: Phases are compared modulo 2^PW, so a phase that wrapped past zero ranks after phases just below the wrap point. Live phases must lie less than 2^PW ahead of the oldest phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_live | input | N | Processor i has a transaction in progress or awaiting commit |
| txn_phase | input | N*PW | Phase of processor i at bits [i*PW +: PW] |
| commit_req | input | N | Processor i asks for commit permission (finished or early) |
| commit_done | input | N | Processor i has finished broadcasting its commit |
| commit_grant | output | N | One-hot commit permission |
| oldest_phase | output | PW | Oldest phase currently allowed to commit |

## Verification
A stale or corrupted oldest-phase register shows up at the ports within one edge. Either a later-phase requester receives a grant, or a waiting barrier never releases and `commit_grant` stays zero while eligible requests are pending.

A round-robin pointer that fails to update shows as the same index winning twice while others wait. A release that is decoded from the wrong done bit shows as a grant dropping early or never dropping.

The directed scenarios therefore sample the grant and the oldest phase on every edge across phase steps, a barrier, and a wrap past zero.

// File: rtl/phase_commit_arbiter.sv
module phase_commit_arbiter #(
  parameter int N  = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  txn_live,
  input  logic [N*PW-1:0] txn_phase,
  input  logic [N-1:0]  commit_req,
  input  logic [N-1:0]  commit_done,
  output logic [N-1:0]  commit_grant,
  output logic [PW-1:0] oldest_phase
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  grant_q;
  logic [N-1:0]  at_oldest;
  logic [N-1:0]  elig;
  logic [PW-1:0] oldest_q;
  logic [PW-1:0] step;
  logic [IW-1:0] last_q;
  logic [IW-1:0] pick;
  logic          found;
  logic          any_live;
  logic          release_now;

  always_comb begin
    for (int i = 0; i < N; i++)
      at_oldest[i] = txn_live[i] && (txn_phase[i*PW +: PW] == oldest_q);
  end

  assign elig        = at_oldest & commit_req;
  assign release_now = |(grant_q & commit_done);

  always_comb begin : rr_pick
    int idx;
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  always_comb begin : next_phase
    logic [PW-1:0] d;
    step     = '0;
    any_live = 1'b0;
    for (int i = 0; i < N; i++) begin
      d = txn_phase[i*PW +: PW] - oldest_q;
      if (txn_live[i] && (!any_live || d < step)) begin
        step     = d;
        any_live = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q  <= '0;
      oldest_q <= '0;
      last_q   <= IW'(N - 1);
    end else if (grant_q != '0) begin
      if (release_now) grant_q <= '0;
    end else if (found) begin
      grant_q <= N'(1) << pick;
      last_q  <= pick;
    end else if (any_live && at_oldest == '0) begin
      oldest_q <= oldest_q + step;
    end
  end

  assign commit_grant = grant_q;
  assign oldest_phase = oldest_q;

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_grant));

  // R3
  eligible_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_grant == '0) |=> (commit_grant == '0) || ((commit_grant & $past(elig)) != '0));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_grant != '0 && (commit_grant & commit_done) == '0) |=> $stable(commit_grant));

  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_grant & commit_done) != '0) |=> (commit_grant == '0));

  // R7
  phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oldest_phase) |-> ($past(commit_grant) == '0 && $past(at_oldest) == '0));
endmodule

// File: tb/tb_phase_commit_arbiter.sv
`timescale 1ns/1ps
module tb_phase_commit_arbiter;
  localparam int N  = 4;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    live = '0;
  logic [N*PW-1:0] phase = '0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    done = '0;
  logic [N-1:0]    grant;
  logic [PW-1:0]   oldest;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  phase_commit_arbiter #(.N(N), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .txn_live(live), .txn_phase(phase),
    .commit_req(req), .commit_done(done),
    .commit_grant(grant), .oldest_phase(oldest));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setp(int i, logic [PW-1:0] p);
    phase[i*PW +: PW] = p;
  endtask

  task automatic t_reset();
    chk("R1 grant after reset", 32'(grant), 0);
    chk("R1 oldest after reset", 32'(oldest), 0);
  endtask

  task automatic t_basic();
    live = 4'b1111; phase = '0; req = 4'b0110;
    step();
    chk("R3/R6 first grant from index 0 search", 32'(grant), 32'b0010);
    done = 4'b1000;
    step();
    chk("R4 foreign done ignored", 32'(grant), 32'b0010);
    done = 4'b0000;
    step();
    chk("R4 grant held", 32'(grant), 32'b0010);
    done = 4'b0010;
    step();
    chk("R5 release on done", 32'(grant), 0);
    done = 0; live[1] = 0; req[1] = 0;
    step();
    chk("R3 next eligible granted", 32'(grant), 32'b0100);
    done = 4'b0100;
    step();
    chk("R5 release", 32'(grant), 0);
    done = 0; live = 0; req = 0;
    step();
    chk("R7 no live keeps phase", 32'(oldest), 0);
  endtask

  task automatic t_rr();
    int order[4] = '{3, 0, 1, 2};
    live = 4'b1111; phase = '0; req = 4'b1111;
    foreach (order[k]) begin
      step();
      chk("R6 round robin order", 32'(grant), 32'(1) << order[k]);
      done = grant;
      step();
      chk("R5 gap after release", 32'(grant), 0);
      done = 0;
    end
    live = 0; req = 0;
    step();
  endtask

  task automatic t_phase();
    live = 4'b0111; setp(0, 0); setp(1, 0); setp(2, 1); setp(3, 0); req = 4'b0100;
    step();
    chk("R3 later phase not granted", 32'(grant), 0);
    chk("R7 phase holds while live at oldest", 32'(oldest), 0);
    req = 4'b0111;
    step();
    chk("R6 barrier member granted", 32'(grant), 32'b0001);
    done = 4'b0001;
    step();
    done = 0; live[0] = 0; req[0] = 0;
    step();
    chk("R3 second barrier member before later phase", 32'(grant), 32'b0010);
    done = 4'b0010;
    step();
    chk("R7 phase holds while grant held", 32'(oldest), 0);
    done = 0; live[1] = 0; req[1] = 0;
    step();
    chk("R7 advance after barrier", 32'(oldest), 1);
    chk("R7 no grant on advance edge", 32'(grant), 0);
    step();
    chk("R3 later phase granted after advance", 32'(grant), 32'b0100);
    done = 4'b0100;
    step();
    done = 0; live = 0; req = 0;
    step();
  endtask

  task automatic t_wrap();
    live = 4'b0001; setp(0, 250);
    step();
    chk("R7 jump to nearest live phase", 32'(oldest), 250);
    live = 4'b0111; setp(1, 3); setp(2, 252); req = 4'b0011;
    step();
    chk("R8 oldest-phase requester wins", 32'(grant), 32'b0001);
    done = 4'b0001;
    step();
    done = 0; live[0] = 0; req[0] = 0;
    step();
    chk("R8 252 before wrapped 3", 32'(oldest), 252);
    chk("R8 wrapped phase waits", 32'(grant), 0);
    live[2] = 0;
    step();
    chk("R8 advance across wrap", 32'(oldest), 3);
    step();
    chk("R8 wrapped requester granted", 32'(grant), 32'b0010);
    done = 4'b0010;
    step();
    done = 0; live = 0; req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    step();
    t_reset();
    t_basic();
    t_rr();
    t_phase();
    t_wrap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule